// File: doc/BRIEF.md
# Scan-Port Reset Request Register

This block is a one-bit test data register that lets a debugger hold the device in reset through the scan port. When the TAP controller has decoded the reset instruction, the bit sits on the serial path from TDI to TDO. It shifts on the data-register clock strobe. The bit has no update stage. Its value drives the reset request directly, so a 1 shifted into it puts the device into reset on the very next cycle.

The request is ORed with the external reset pin (active low) and with a vector of other internal reset sources. When every source has gone quiet, a down-counter keeps the internal reset asserted for a selectable time-out of 0, 16, 256 or 4096 cycles. Any source that becomes active again reloads the counter. While the internal reset is asserted, the port pins are told to go tri-state. Holding a 1 in the bit therefore also serves as a way to put every output in high impedance.

The TAP state machine and the clock-source configuration sit outside this block. Their strobes, the decoded-instruction flag and the time-out select arrive as inputs, all synchronous to `clk`.

Top module: `jtag_reset_tdr`

## Requirements
- R1: While the request bit holds 1, `core_rst` is 1. A 1 in the bit means reset is requested.
- R2: `core_rst` is also 1 while `ext_rst_n` is 0 or while any bit of `other_rst` is 1. Every source is ORed in.
- R3: On a clock edge with `sel_rst_insn`, `dr_clk_en` and `shift_dr` all 1, the bit loads `tdi`. `core_rst` reflects the new value from that edge on, and no update strobe is needed.
- R4: The bit keeps its value on any edge where `sel_rst_insn` is 0, where `dr_clk_en` is 0, or where `shift_dr` is 0 (capture).
- R5: `tap_reset` high at an edge clears the bit to 0, and this takes priority over shifting. The block reset `rst` also clears it.
- R6: `tdo` equals the bit while `sel_rst_insn` is 1, and is 0 otherwise.
- R7: After the last cycle with any source active, `core_rst` stays 1 for exactly T further cycles. T is set by `tmo_sel`: 00 gives 0, 01 gives 16, 10 gives 256 and 11 gives 4096.
- R8: A source that becomes active again during the time-out restarts it. After the final release, the full T cycles run again.
- R9: `pins_hiz` is 1 exactly when `core_rst` is 1.
- R10: After `rst`, the bit is 0, the counter is empty, `core_rst` is 0 (with no other source active) and `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; scan strobes are synchronous enables on it |
| rst | input | 1 | Synchronous active-high block reset |
| tap_reset | input | 1 | Test-logic-reset state from the TAP controller |
| dr_clk_en | input | 1 | One-cycle data-register clock strobe |
| shift_dr | input | 1 | TAP is in the shift state for data registers |
| sel_rst_insn | input | 1 | Reset instruction is the decoded instruction |
| tdi | input | 1 | Serial scan data in |
| tdo | output | 1 | Serial scan data out |
| ext_rst_n | input | 1 | External reset pin, active low |
| other_rst | input | NSRC | Other internal reset sources, active high |
| tmo_sel | input | 2 | Post-release time-out select |
| core_rst | output | 1 | Internal reset to the device |
| pins_hiz | output | 1 | Tri-state request for all port outputs |

## Verification
The assertions assume that every input changes only between clock edges. They also assume that `dr_clk_en` is a one-cycle strobe and that `tap_reset` is sampled as a level on the same clock. The time-out select is taken to be stable while a release is being timed. The reload check compares the counter against the select value seen on the previous edge. The bench changes every input on the falling edge, holds `tmo_sel` constant across each timed release and drives the strobes for single cycles. It keeps the select at zero while it walks the shift and combine vectors, so that reset there follows the sources with no delay.

// File: rtl/jrst_pkg.sv
package jrst_pkg;

    typedef enum logic [1:0] {
        TMO_NONE  = 2'b00,
        TMO_SHORT = 2'b01,
        TMO_MID   = 2'b10,
        TMO_LONG  = 2'b11
    } tmo_sel_e;

    // Cycles of post-release stretch: 0 or 2^(step*sel)
    function automatic int unsigned tmo_cycles(input logic [1:0] sel, input int unsigned step);
        if (sel == TMO_NONE) return 0;
        return 32'd1 << (step * int'(sel));
    endfunction

endpackage

// File: rtl/jrst_shift_bit.sv
module jrst_shift_bit (
    input  logic clk,
    input  logic rst,
    input  logic tap_reset,
    input  logic dr_clk_en,
    input  logic shift_dr,
    input  logic sel,
    input  logic tdi,
    output logic q,
    output logic tdo
);
    logic shift_now;
    assign shift_now = dr_clk_en && sel && shift_dr;

    always_ff @(posedge clk) begin
        if (rst || tap_reset) q <= 1'b0;
        else if (shift_now)   q <= tdi;
    end

    assign tdo = sel ? q : 1'b0;

    AST_SHIFT_LOADS_TDI: assert property (@(posedge clk) disable iff (rst)
        (dr_clk_en && sel && shift_dr && !tap_reset) |=> (q == $past(tdi))); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!tap_reset && !(dr_clk_en && sel && shift_dr)) |=> $stable(q)); // R4
    AST_TLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        tap_reset |=> !q); // R5
endmodule

// File: rtl/jrst_combine.sv
module jrst_combine #(
    parameter int NSRC = 2
) (
    input  logic            req_bit,
    input  logic            ext_rst_n,
    input  logic [NSRC-1:0] other_rst,
    output logic            active
);
    logic [NSRC+1:0] srcs;
    assign srcs   = {other_rst, ~ext_rst_n, req_bit};
    assign active = |srcs;
endmodule

// File: rtl/jrst_stretch.sv
module jrst_stretch
    import jrst_pkg::*;
#(
    parameter int STEP = 4,
    parameter int CW   = 3 * STEP + 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic [1:0] tmo_sel,
    output logic       stretched
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;

    assign load_val = CW'(tmo_cycles(tmo_sel, STEP));

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (active)      cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign stretched = active || (cnt != '0);

    AST_RELOAD_ON_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        active |=> (cnt == CW'(tmo_cycles($past(tmo_sel), STEP)))); // R8
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!active && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R7
    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!active && cnt == '0) |=> (cnt == '0)); // R7
endmodule

// File: rtl/jtag_reset_tdr.sv
module jtag_reset_tdr
    import jrst_pkg::*;
#(
    parameter int NSRC = 2,
    parameter int STEP = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tap_reset,
    input  logic            dr_clk_en,
    input  logic            shift_dr,
    input  logic            sel_rst_insn,
    input  logic            tdi,
    output logic            tdo,
    input  logic            ext_rst_n,
    input  logic [NSRC-1:0] other_rst,
    input  logic [1:0]      tmo_sel,
    output logic            core_rst,
    output logic            pins_hiz
);
    localparam int CW = 3 * STEP + 1;

    logic req_bit;
    logic any_active;

    jrst_shift_bit u_bit (
        .clk       (clk),
        .rst       (rst),
        .tap_reset (tap_reset),
        .dr_clk_en (dr_clk_en),
        .shift_dr  (shift_dr),
        .sel       (sel_rst_insn),
        .tdi       (tdi),
        .q         (req_bit),
        .tdo       (tdo)
    );

    jrst_combine #(.NSRC(NSRC)) u_comb (
        .req_bit   (req_bit),
        .ext_rst_n (ext_rst_n),
        .other_rst (other_rst),
        .active    (any_active)
    );

    jrst_stretch #(.STEP(STEP), .CW(CW)) u_str (
        .clk       (clk),
        .rst       (rst),
        .active    (any_active),
        .tmo_sel   (tmo_sel),
        .stretched (core_rst)
    );

    assign pins_hiz = core_rst;

    AST_BIT_FORCES_RESET: assert property (@(posedge clk) disable iff (rst)
        req_bit |-> core_rst); // R1
    AST_PIN_FORCES_RESET: assert property (@(posedge clk) disable iff (rst)
        (!ext_rst_n || (|other_rst)) |-> core_rst); // R2
    AST_SHIFT_ONE_RESETS: assert property (@(posedge clk) disable iff (rst)
        (dr_clk_en && sel_rst_insn && shift_dr && tdi && !tap_reset) |=> core_rst); // R3
endmodule

// File: tb/jtag_reset_tdr_bench.sv
module jtag_reset_tdr_bench;
    localparam int NSRC = 2;

    logic clk = 1'b0;
    logic rst, tap_reset, dr_clk_en, shift_dr, sel_rst_insn, tdi, ext_rst_n;
    logic [NSRC-1:0] other_rst;
    logic [1:0] tmo_sel;
    logic tdo, core_rst, pins_hiz;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    jtag_reset_tdr #(.NSRC(NSRC), .STEP(4)) u_jtag_reset_tdr (
        .clk(clk), .rst(rst), .tap_reset(tap_reset), .dr_clk_en(dr_clk_en),
        .shift_dr(shift_dr), .sel_rst_insn(sel_rst_insn), .tdi(tdi), .tdo(tdo),
        .ext_rst_n(ext_rst_n), .other_rst(other_rst), .tmo_sel(tmo_sel),
        .core_rst(core_rst), .pins_hiz(pins_hiz)
    );

    // [9]sel [8]clk_en [7]shift [6]tdi [5]tap_reset [4]ext_rst_n [3:2]other [1]exp_tdo [0]exp_core_rst
    localparam int NV = 12;
    localparam logic [9:0] VEC [NV] = '{
        10'b1111010011,  // shift 1 in: reset at once (R3, R1)
        10'b0110010001,  // not selected: bit holds (R4, R6)
        10'b1010010011,  // no strobe: bit holds (R4)
        10'b1100010011,  // capture: bit holds (R4)
        10'b1110010000,  // shift 0 in: reset drops (R3)
        10'b1000000001,  // external pin low (R2)
        10'b1000010101,  // other source 0 (R2)
        10'b1000011001,  // other source 1 (R2)
        10'b1000010000,  // all quiet
        10'b1111010011,  // shift 1 again (R3)
        10'b1111110000,  // tap reset beats shift (R5)
        10'b0001010000   // tdo forced low when not selected (R6)
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        tap_reset = 0; dr_clk_en = 0; shift_dr = 0; sel_rst_insn = 0; tdi = 0;
        ext_rst_n = 1; other_rst = '0;
    endtask

    // Release happens at the current falling edge; count cycles reset stays high
    task automatic measure(output int n);
        n = 0;
        #1;
        while (core_rst && n < 6000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        idle_inputs();
        tmo_sel = 2'b00;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R10 core_rst", core_rst, 1'b0);
        check("R10 tdo", tdo, 1'b0);
        sel_rst_insn = 1;
        #1;
        check("R10 bit via tdo", tdo, 1'b0);
        check("R9 hiz idle", pins_hiz, 1'b0);

        for (int i = 0; i < NV; i++) begin
            sel_rst_insn = VEC[i][9]; dr_clk_en = VEC[i][8]; shift_dr = VEC[i][7];
            tdi = VEC[i][6]; tap_reset = VEC[i][5]; ext_rst_n = VEC[i][4];
            other_rst = VEC[i][3:2];
            @(negedge clk);
            dr_clk_en = 0; tap_reset = 0;
            check($sformatf("R1/R2/R3/R4/R5/R6 vector %0d tdo", i), tdo, VEC[i][1]);
            check($sformatf("R1/R2/R3/R4/R5/R6 vector %0d core_rst", i), core_rst, VEC[i][0]);
            check($sformatf("R9 vector %0d pins_hiz", i), pins_hiz, VEC[i][0]);
        end

        // R7: each time-out setting, released from a scan-held reset
        for (int s = 0; s < 4; s++) begin
            idle_inputs();
            tmo_sel = 2'(s);
            sel_rst_insn = 1; dr_clk_en = 1; shift_dr = 1; tdi = 1;
            @(negedge clk);
            dr_clk_en = 0;
            @(negedge clk);
            check("R1 held by bit", core_rst, 1'b1);
            dr_clk_en = 1; tdi = 0;
            @(negedge clk);
            dr_clk_en = 0;
            // bit cleared at the edge just passed: that edge was the first quiet cycle
            n = 0;
            while (core_rst && n < 6000) begin
                @(negedge clk);
                n++;
            end
            check_int($sformatf("R7 stretch sel=%0d", s), n + 1,
                      (s == 0) ? 1 : (1 << (4 * s)) + 1);
        end

        // R7 via external pin, exact count from the release cycle
        idle_inputs();
        tmo_sel = 2'b01;
        ext_rst_n = 0;
        @(negedge clk);
        ext_rst_n = 1;
        measure(n);
        check_int("R7 pin release sel=01", n, 16);

        // R8: re-assert midway restarts the full time-out
        other_rst = 2'b10;
        @(negedge clk);
        other_rst = '0;
        repeat (8) @(negedge clk);
        check("R8 mid stretch", core_rst, 1'b1);
        other_rst = 2'b01;
        @(negedge clk);
        other_rst = '0;
        measure(n);
        check_int("R8 reload length", n, 16);
        check("R9 hiz after release", pins_hiz, 1'b0);

        // R5: tap reset clears a held 1, observed at the ports
        tmo_sel = 2'b00;
        sel_rst_insn = 1; dr_clk_en = 1; shift_dr = 1; tdi = 1;
        @(negedge clk);
        dr_clk_en = 0;
        tap_reset = 1;
        @(negedge clk);
        tap_reset = 0;
        check("R5 tap reset tdo", tdo, 1'b0);
        check("R5 tap reset core_rst", core_rst, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule